// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

A bank of eight hardware semaphore latches shared by a left and a right port. The latches hold no memory contents. Each one records which side, if any, owns a shared resource, and whether each side is waiting for it. A port reaches a latch by raising its semaphore select while its memory enable is low. The low three address bits choose the latch.

A port asks for a latch by writing 0 on its write bit and gives it up by writing 1. Reading a latch returns 0 on data bit 0 when the reading side owns it, and 1 otherwise. All the other read bits are always 1. A request against a held latch is remembered. When the holder releases the latch, ownership passes to the waiting side on that same clock edge, so the waiting side only has to poll until it reads 0.

All state and the read data are registered on the rising clock edge. A read reports the ownership as it stood before any write accepted at the same edge.

Top module: `sem_latch_bank`

## Requirements
- R1: After reset no latch is owned or requested, and a read of any latch from either side returns 8'hFF.
- R2: Address bits [2:0] select one of eight latches, and an access to one latch leaves the state of every other latch unchanged.
- R3: A write with write bit 0 to a free latch gives that side ownership. Its next read of the latch returns 8'hFE (bit 0 = 0, bits 7:1 = 1).
- R4: A write with write bit 0 to a latch the other side owns leaves that latch pending for the writer. The writer reads 8'hFF and the owner keeps reading 8'hFE.
- R5: When the owner writes 1 and the other side is pending, the pending side becomes owner at that same clock edge.
- R6: Writing 1 clears the writer's ownership or its pending request. After a cancelled request, a later release by the owner leaves the latch free.
- R7: When both sides request the same free latch at the same edge, the left side owns it and the right side is left pending.
- R8: A read (select high, memory enable low, read enable high, write enable low) updates the read data one clock edge after it is presented, using the state before that edge's writes. The read data then holds until the next read.
- R9: An access with select and memory enable both high is illegal and is ignored. No latch changes and the read data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; illegal together with l_sel |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left read enable |
| l_addr | input | 3 | Left latch index |
| l_wbit | input | 1 | Left write bit: 0 request, 1 release |
| l_rdata | output | 8 | Left read data |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; illegal together with r_sel |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right read enable |
| r_addr | input | 3 | Right latch index |
| r_wbit | input | 1 | Right write bit: 0 request, 1 release |
| r_rdata | output | 8 | Right read data |

## Verification
Ownership and pending state change at the first rising edge that sees a write. Read data shows the result of a read at the first rising edge that sees that read. A write's effect can therefore first be read on the next cycle. The bench drives each cycle's inputs on the falling edge and samples one nanosecond after the following rising edge. A read that shares a cycle with a write is expected to return the pre-write value, and a cycle with no read must show the data unchanged.

// File: rtl/sem_latch_bank.sv
module sem_latch_bank #(
  parameter int NUM = 8,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   l_sel,
  input  logic                   l_mem_en,
  input  logic                   l_we,
  input  logic                   l_oe,
  input  logic [$clog2(NUM)-1:0] l_addr,
  input  logic                   l_wbit,
  output logic [DW-1:0]          l_rdata,
  input  logic                   r_sel,
  input  logic                   r_mem_en,
  input  logic                   r_we,
  input  logic                   r_oe,
  input  logic [$clog2(NUM)-1:0] r_addr,
  input  logic                   r_wbit,
  output logic [DW-1:0]          r_rdata
);
  localparam int AW = $clog2(NUM);

  logic l_acc, r_acc, l_wr, r_wr, l_rd, r_rd;
  logic [NUM-1:0] own_l, own_r, pend_l, pend_r;
  logic [NUM-1:0] req_l, req_r, rel_l, rel_r;

  assign l_acc = l_sel & ~l_mem_en;
  assign r_acc = r_sel & ~r_mem_en;
  assign l_wr  = l_acc & l_we;
  assign r_wr  = r_acc & r_we;
  assign l_rd  = l_acc & l_oe & ~l_we;
  assign r_rd  = r_acc & r_oe & ~r_we;

  for (genvar i = 0; i < NUM; i++) begin : g_latch
    logic hit_l, hit_r;
    logic keep_l, keep_r, want_l, want_r, free, grant_l, grant_r;

    assign hit_l    = l_wr && (l_addr == AW'(i));
    assign hit_r    = r_wr && (r_addr == AW'(i));
    assign req_l[i] = hit_l & ~l_wbit;
    assign rel_l[i] = hit_l &  l_wbit;
    assign req_r[i] = hit_r & ~r_wbit;
    assign rel_r[i] = hit_r &  r_wbit;

    assign keep_l  = own_l[i] & ~rel_l[i];
    assign keep_r  = own_r[i] & ~rel_r[i];
    assign want_l  = (pend_l[i] | (req_l[i] & ~own_l[i])) & ~rel_l[i];
    assign want_r  = (pend_r[i] | (req_r[i] & ~own_r[i])) & ~rel_r[i];
    assign free    = ~keep_l & ~keep_r;
    assign grant_l = free & want_l;
    assign grant_r = free & want_r & ~want_l;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_l[i]  <= 1'b0;
        own_r[i]  <= 1'b0;
        pend_l[i] <= 1'b0;
        pend_r[i] <= 1'b0;
      end else begin
        own_l[i]  <= keep_l | grant_l;
        own_r[i]  <= keep_r | grant_r;
        pend_l[i] <= want_l & ~grant_l;
        pend_r[i] <= want_r & ~grant_r;
      end
    end

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_l[i] && own_r[i]));
    assert_free_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l[i] && !own_r[i] && req_l[i]) |=> own_l[i]);
    assert_handover_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r[i] && pend_l[i] && rel_r[i] && !rel_l[i]) |=> own_l[i]);
    assert_handover_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && pend_r[i] && rel_l[i] && !rel_r[i]) |=> own_r[i]);
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rel_l[i] |=> (!own_l[i] && !pend_l[i]));
    assert_left_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l[i] && !own_r[i] && req_l[i] && req_r[i]) |=> (own_l[i] && pend_r[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      if (l_rd) l_rdata <= {{(DW-1){1'b1}}, ~own_l[l_addr]};
      if (r_rd) r_rdata <= {{(DW-1){1'b1}}, ~own_r[r_addr]};
    end
  end

  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && l_mem_en) |=> $stable(l_rdata));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_sel && !r_mem_en && r_oe && !r_we) |=> $stable(r_rdata));
endmodule

// File: tb/sem_latch_bank_bench.sv
module sem_latch_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic l_sel, l_mem_en, l_we, l_oe, l_wbit, r_sel, r_mem_en, r_we, r_oe, r_wbit;
  logic [2:0] l_addr, r_addr;
  logic [7:0] l_rdata, r_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sem_latch_bank u_sem_latch_bank (.*);

  // op: 0 idle, 1 request, 2 release, 3 read ; x: expected bit0 of a read
  // {lop[1:0], laddr[2:0], rop[1:0], raddr[2:0], lx, rx}
  localparam logic [11:0] VEC [19] = '{
    {2'd1,3'd0,2'd0,3'd0,1'b1,1'b1},
    {2'd3,3'd0,2'd3,3'd0,1'b0,1'b1},
    {2'd0,3'd0,2'd1,3'd0,1'b1,1'b1},
    {2'd3,3'd0,2'd3,3'd0,1'b0,1'b1},
    {2'd2,3'd0,2'd3,3'd3,1'b1,1'b1},
    {2'd3,3'd0,2'd3,3'd0,1'b1,1'b0},
    {2'd1,3'd1,2'd1,3'd1,1'b1,1'b1},
    {2'd3,3'd1,2'd3,3'd1,1'b0,1'b1},
    {2'd2,3'd1,2'd0,3'd0,1'b1,1'b1},
    {2'd3,3'd1,2'd3,3'd1,1'b1,1'b0},
    {2'd1,3'd2,2'd1,3'd5,1'b1,1'b1},
    {2'd3,3'd5,2'd3,3'd2,1'b1,1'b1},
    {2'd3,3'd2,2'd3,3'd5,1'b0,1'b0},
    {2'd0,3'd0,2'd1,3'd2,1'b1,1'b1},
    {2'd0,3'd0,2'd2,3'd2,1'b1,1'b1},
    {2'd2,3'd2,2'd0,3'd0,1'b1,1'b1},
    {2'd3,3'd2,2'd3,3'd2,1'b1,1'b1},
    {2'd0,3'd0,2'd1,3'd2,1'b1,1'b1},
    {2'd3,3'd2,2'd3,3'd2,1'b1,1'b0}
  };
  localparam string VTAG [19] = '{"R3","R3","R4","R4","R5","R5","R7","R7","R7",
    "R5","R2","R2","R2","R4","R6","R6","R6","R6","R6"};

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // kind: 0 idle, 1 request, 2 release, 3 read, 4 illegal write bit0=0, 5 illegal read
  task automatic set_l(int kind, logic [2:0] a);
    l_sel = kind != 0; l_mem_en = kind >= 4; l_addr = a;
    l_we = kind inside {1, 2, 4}; l_oe = kind inside {3, 5}; l_wbit = kind == 2;
  endtask
  task automatic set_r(int kind, logic [2:0] a);
    r_sel = kind != 0; r_mem_en = kind >= 4; r_addr = a;
    r_we = kind inside {1, 2, 4}; r_oe = kind inside {3, 5}; r_wbit = kind == 2;
  endtask
  task automatic tick;
    @(posedge clk); #1;
    @(negedge clk);
  endtask
  task automatic edge_sample;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    set_l(0, 0); set_r(0, 0);
    repeat (3) @(negedge clk);
    check("R1", l_rdata, 8'hFF);
    check("R1", r_rdata, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      set_l(3, 3'(a)); set_r(3, 3'(a));
      edge_sample;
      check("R1", l_rdata, 8'hFF);
      check("R1", r_rdata, 8'hFF);
      @(negedge clk);
    end

    for (int v = 0; v < 19; v++) begin
      logic [11:0] e;
      e = VEC[v];
      set_l(int'(e[11:10]), e[9:7]);
      set_r(int'(e[6:5]), e[4:2]);
      edge_sample;
      if (e[11:10] == 2'd3) check(VTAG[v], l_rdata, {7'h7F, e[1]});
      if (e[6:5] == 2'd3)   check(VTAG[v], r_rdata, {7'h7F, e[0]});
      @(negedge clk);
    end

    // R8: read sees state before a same-edge write by the other side
    set_l(1, 4); set_r(3, 4);
    edge_sample; check("R8", r_rdata, 8'hFF);
    @(negedge clk);
    set_l(3, 4); set_r(3, 4);
    edge_sample; check("R8", l_rdata, 8'hFE); check("R8", r_rdata, 8'hFF);
    @(negedge clk);
    set_l(0, 0); set_r(0, 0);
    edge_sample; check("R8", l_rdata, 8'hFE);
    @(negedge clk);

    // R9: illegal accesses ignored
    set_l(3, 3); tick;
    set_l(5, 4);
    edge_sample; check("R9", l_rdata, 8'hFF);
    @(negedge clk);
    set_l(4, 6); tick;
    set_l(3, 6);
    edge_sample; check("R9", l_rdata, 8'hFF);
    @(negedge clk);
    set_l(3, 4);
    edge_sample; check("R9", l_rdata, 8'hFE);
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule